// File: doc/BRIEF.md
# Normalizing Barrel Shifter Unit

This block is the shift stage of a 16-bit fixed-point datapath. Each cycle in which `op_valid` is high it takes one 16-bit operand, a 3-bit operation code and an 8-bit two's-complement shift amount. At the next clock edge it writes a 40-bit result register. The operations are logical and arithmetic shifts in either direction, normalization, denormalization and exponent derivation.

The operand can sit in the lower or the upper 16-bit slot of the 40-bit field. An OR mode merges a new shifted value with the result already held. Together these let software build wider values out of 16-bit pieces.

A block-exponent register keeps the smallest exponent derived since it was last cleared. Software can derive the exponent of every sample in a block and then scale the whole block by one common amount. Rounding is truncation only.

Top module: `nsh_unit`

## Requirements
- R1: During and after reset, `result` is 0, `exp_val` is 0 and `blk_exp` is 15.
- R2: Opcode 3'b000 is a logical shift. The operand is zero-extended into the field. A positive `shamt` shifts left, a negative `shamt` shifts right by its magnitude, and vacated bits fill with 0. The result appears after the first rising edge that samples the operation.
- R3: Opcode 3'b001 is an arithmetic shift. The operand is sign-extended into the field. A right shift fills with copies of `din[15]` and a left shift fills with 0.
- R4: A shift magnitude of 40 or more, including -128, gives all zeros. The one exception is an arithmetic right shift, which gives 40 copies of the sign bit.
- R5: With `hi_sel`=1 the operand is placed in bits 31:16 and bits 15:0 are 0. With `hi_sel`=0 it is placed in bits 15:0. Bits above the operand hold the extension (zero or sign) of the operation.
- R6: Opcode 3'b100 writes `exp_val` with the number of bits directly below `din[15]` that equal `din[15]`, giving a value from 0 to 15. An all-zero or all-ones operand gives 15. `result` is unchanged.
- R7: Opcode 3'b010 normalizes. It shifts the sign-extended field left by the derived exponent of `din` and ignores `shamt`. `exp_val` is unchanged.
- R8: Opcode 3'b011 denormalizes. It shifts the sign-extended field right arithmetically by the magnitude of `shamt`.
- R9: With `or_mode`=1, any shift opcode (000 to 011) writes the bitwise OR of the new shifted value and the previous `result`.
- R10: Every opcode-100 operation sets `blk_exp` to the minimum of its stored value and the new exponent. `blk_clr` sets `blk_exp` to 15, whether or not `op_valid` is high. When `blk_clr` and an opcode-100 operation share a cycle, `blk_exp` becomes the new exponent.
- R11: When `op_valid`=0, or the opcode is 3'b101 to 3'b111, `result`, `exp_val` and `blk_exp` keep their values (apart from the effect of `blk_clr`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation strobe and clock enable |
| op_code | input | 3 | Operation select |
| hi_sel | input | 1 | 1 places the operand in the upper slot (bits 31:16) |
| or_mode | input | 1 | OR the new shift into the previous result |
| shamt | input | 8 | Signed shift amount; positive shifts left |
| din | input | 16 | Operand |
| blk_clr | input | 1 | Reset the block exponent to 15 |
| result | output | 40 | Result register |
| exp_val | output | 4 | Last derived exponent |
| blk_exp | output | 4 | Smallest exponent since the last clear |

## Verification
The bench drives amounts of exactly 39, 40, 127 and -128. A magnitude comparison that is off by one, or that wraps -128 to zero, would leave residue bits or return the unshifted operand.

Sign fill is exercised with negative operands in both slots. A design that filled with zeros, or sign-extended only the low slot, would give wrong upper bits on arithmetic and denormalize right shifts.

Exponent derivation is checked on all-zero, all-ones, 0x4000 and 0xBFFF operands, where a counter that ran one bit too far or stopped one bit early would report 16 or 14.

Block-exponent clearing is checked on its own, during an operation, and on the same cycle as an exponent operation. A wrong priority would leave 15 where the new exponent belongs.

// File: rtl/nsh_pkg.sv
package nsh_pkg;
  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXP    = 3'd4
  } nsh_op_e;
endpackage

// File: rtl/nsh_expdet.sv
module nsh_expdet #(
  parameter int DW = 16,
  localparam int EW = $clog2(DW)
) (
  input  logic [DW-1:0] opnd,
  output logic [EW-1:0] expo
);
  always_comb begin
    logic run;
    expo = '0;
    run  = 1'b1;
    for (int i = DW-2; i >= 0; i--) begin
      if (run && (opnd[i] == opnd[DW-1])) expo = expo + EW'(1);
      else run = 1'b0;
    end
  end
endmodule

// File: rtl/nsh_barrel.sv
module nsh_barrel #(
  parameter int RW = 40,
  parameter int SW = 8,
  localparam int LW = $clog2(RW)
) (
  input  logic [RW-1:0] fld,
  input  logic [SW-1:0] mag,
  input  logic          left,
  input  logic          fill,
  output logic [RW-1:0] q
);
  logic [RW-1:0] stg [LW+1];
  assign stg[0] = fld;

  for (genvar k = 0; k < LW; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [RW-1:0] lft, rgt;
    assign lft = {stg[k][RW-1-SH:0], {SH{1'b0}}};
    assign rgt = {{SH{fill}}, stg[k][RW-1:SH]};
    assign stg[k+1] = mag[k] ? (left ? lft : rgt) : stg[k];
  end

  logic too_far;
  assign too_far = (mag >= SW'(RW));

  always_comb begin
    if (too_far) q = left ? '0 : {RW{fill}};
    else         q = stg[LW];
  end
endmodule

// File: rtl/nsh_blkexp.sv
module nsh_blkexp #(
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [EW-1:0] e_in,
  output logic [EW-1:0] blk_q
);
  localparam logic [EW-1:0] EMAX = '1;
  logic [EW-1:0] blk_d;
  logic          blk_en;

  always_comb begin
    blk_en = clr | upd;
    blk_d  = blk_q;
    if (clr && upd)           blk_d = e_in;
    else if (clr)             blk_d = EMAX;
    else if (upd && e_in < blk_q) blk_d = e_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= EMAX;
    else if (blk_en) blk_q <= blk_d;
  end

  // R10
  blk_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> blk_q <= $past(e_in));
  // R10
  blk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !upd) |=> blk_q == EMAX);
endmodule

// File: rtl/nsh_unit.sv
module nsh_unit #(
  parameter int DW = 16,
  parameter int RW = 40,
  parameter int SW = 8,
  localparam int EW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic          hi_sel,
  input  logic          or_mode,
  input  logic [SW-1:0] shamt,
  input  logic [DW-1:0] din,
  input  logic          blk_clr,
  output logic [RW-1:0] result,
  output logic [EW-1:0] exp_val,
  output logic [EW-1:0] blk_exp
);
  import nsh_pkg::*;

  localparam int HIPOS = 2*DW;
  localparam int HEXT  = RW - HIPOS;
  localparam int LEXT  = RW - DW;

  logic rst_s1, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  nsh_op_e       op;
  logic          arith, left, fill, is_shift;
  logic [SW-1:0] mag, abs_amt;
  logic [RW-1:0] fld, sh_q;
  logic [EW-1:0] e_now;
  logic [RW-1:0] res_q, res_d;
  logic [EW-1:0] exp_q, exp_d;
  logic          res_en, exp_en;

  nsh_expdet #(.DW(DW)) u_expdet (.opnd(din), .expo(e_now));

  always_comb begin
    op       = nsh_op_e'(op_code);
    abs_amt  = shamt[SW-1] ? (~shamt + SW'(1)) : shamt;
    arith    = 1'b1;
    left     = 1'b0;
    mag      = abs_amt;
    is_shift = 1'b1;
    case (op)
      OP_LSH:    begin arith = 1'b0; left = ~shamt[SW-1]; end
      OP_ASH:    left = ~shamt[SW-1];
      OP_NORM:   begin left = 1'b1; mag = SW'(e_now); end
      OP_DENORM: left = 1'b0;
      default:   is_shift = 1'b0;
    endcase
    fill = arith & din[DW-1];
    if (hi_sel) fld = {{HEXT{fill}}, din, {DW{1'b0}}};
    else        fld = {{LEXT{fill}}, din};
  end

  nsh_barrel #(.RW(RW), .SW(SW)) u_barrel (
    .fld(fld), .mag(mag), .left(left), .fill(fill), .q(sh_q)
  );

  always_comb begin
    res_en = op_valid & is_shift;
    exp_en = op_valid & (op == OP_EXP);
    res_d  = or_mode ? (sh_q | res_q) : sh_q;
    exp_d  = e_now;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)   res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)   exp_q <= '0;
    else if (exp_en) exp_q <= exp_d;
  end

  nsh_blkexp #(.EW(EW)) u_blkexp (
    .clk(clk), .rst_n(rst_sync), .clr(blk_clr), .upd(exp_en),
    .e_in(e_now), .blk_q(blk_exp)
  );

  assign result  = res_q;
  assign exp_val = exp_q;

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !op_valid |=> (res_q == $past(res_q)) && (exp_q == $past(exp_q)));
  // R6
  exp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (op_valid && op_code == 3'd4) |=> res_q == $past(res_q));
  // R4
  far_left_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (op_valid && op_code == 3'd0 && !or_mode && $signed(shamt) >= 40) |=> res_q == '0);
  // R7
  norm_keeps_exp_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (op_valid && op_code == 3'd2) |=> exp_q == $past(exp_q));
endmodule

// File: tb/nsh_unit_bench.sv
module nsh_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, hi_sel, or_mode, blk_clr;
  logic [2:0]  op_code;
  logic [7:0]  shamt;
  logic [15:0] din;
  logic [39:0] result;
  logic [3:0]  exp_val, blk_exp;

  always #2 clk = ~clk;

  nsh_unit u_nsh_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .hi_sel(hi_sel), .or_mode(or_mode), .shamt(shamt), .din(din),
    .blk_clr(blk_clr), .result(result), .exp_val(exp_val), .blk_exp(blk_exp)
  );

  typedef struct {
    logic [39:0] res;
    logic [3:0]  ex;
    logic [3:0]  blk;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [39:0] m_res = '0;
  logic [3:0]  m_exp = '0, m_blk = 4'hF;

  function automatic logic [3:0] ref_exp(input logic [15:0] d);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      n++;
    end
    return 4'(n);
  endfunction

  function automatic logic [39:0] ref_place(input logic [15:0] d, input logic h, input logic ar);
    logic [39:0] ext = ar ? {40{d[15]}} : '0;
    if (h) return {ext[7:0], d, 16'h0};
    return {ext[23:0], d};
  endfunction

  function automatic logic [39:0] ref_shift(input logic [39:0] f, input int amt, input logic fl);
    int m;
    if (amt >= 0) return (amt >= 40) ? '0 : (f << amt);
    m = -amt;
    if (m >= 40) return {40{fl}};
    return fl ? ~((~f) >> m) : (f >> m);
  endfunction

  task automatic drive(input logic v, input logic [2:0] oc, input logic h, input logic om,
                       input int amt, input logic [15:0] d, input logic clr, input string tag);
    exp_t it;
    logic [39:0] f, s;
    logic ar, fl, sh;
    int a;
    @(negedge clk);
    op_valid = v; op_code = oc; hi_sel = h; or_mode = om;
    shamt = 8'(amt); din = d; blk_clr = clr;
    a  = int'($signed(8'(amt)));
    ar = (oc != 3'd0);
    fl = ar & d[15];
    f  = ref_place(d, h, ar);
    sh = 1'b1;
    case (oc)
      3'd0, 3'd1: s = ref_shift(f, a, fl);
      3'd2:       s = ref_shift(f, int'(ref_exp(d)), fl);
      3'd3:       s = ref_shift(f, -((a < 0) ? -a : a), fl);
      default:    begin s = '0; sh = 1'b0; end
    endcase
    if (v && sh) m_res = om ? (s | m_res) : s;
    if (v && oc == 3'd4) m_exp = ref_exp(d);
    if (clr && v && oc == 3'd4) m_blk = ref_exp(d);
    else if (clr) m_blk = 4'hF;
    else if (v && oc == 3'd4 && ref_exp(d) < m_blk) m_blk = ref_exp(d);
    it.res = m_res; it.ex = m_exp; it.blk = m_blk; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (result !== it.res || exp_val !== it.ex || blk_exp !== it.blk) begin
          fails++;
          $display("FAIL %s: got res=%h exp=%0d blk=%0d, expected res=%h exp=%0d blk=%0d",
                   it.tag, result, exp_val, blk_exp, it.res, it.ex, it.blk);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin : stim
    rst_n = 0; op_valid = 0; op_code = 0; hi_sel = 0; or_mode = 0;
    shamt = 0; din = 0; blk_clr = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (result !== '0 || exp_val !== 4'd0 || blk_exp !== 4'hF) begin
      fails++;
      $display("FAIL R1: got res=%h exp=%0d blk=%0d, expected 0/0/15", result, exp_val, blk_exp);
    end
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    // R2 logical shifts
    drive(1, 3'd0, 0, 0, 4,    16'h8001, 0, "R2 lsl lo");
    drive(1, 3'd0, 0, 0, -3,   16'h8001, 0, "R2 lsr lo");
    drive(1, 3'd0, 0, 0, 39,   16'h0001, 0, "R2 lsl 39");
    drive(1, 3'd0, 0, 0, 0,    16'hABCD, 0, "R2 zero amount");
    // R3 arithmetic
    drive(1, 3'd1, 0, 0, -4,   16'h8000, 0, "R3 asr neg");
    drive(1, 3'd1, 0, 0, 5,    16'hF00F, 0, "R3 asl");
    drive(1, 3'd1, 1, 0, -8,   16'h9234, 0, "R3 asr hi");
    // R4 far amounts
    drive(1, 3'd0, 0, 0, 40,   16'hFFFF, 0, "R4 lsl 40");
    drive(1, 3'd1, 0, 0, -40,  16'h8000, 0, "R4 asr 40 neg");
    drive(1, 3'd1, 1, 0, -128, 16'h7000, 0, "R4 asr -128 pos");
    drive(1, 3'd1, 0, 0, -128, 16'hC000, 0, "R4 asr -128 neg");
    drive(1, 3'd0, 0, 0, 127,  16'h1234, 0, "R4 lsl 127");
    drive(1, 3'd0, 1, 0, -39,  16'h8000, 0, "R4 lsr 39 hi");
    // R5 placement
    drive(1, 3'd0, 1, 0, 0,    16'hBEEF, 0, "R5 hi logical");
    drive(1, 3'd1, 1, 0, 0,    16'hBEEF, 0, "R5 hi arith");
    drive(1, 3'd1, 0, 0, 0,    16'hBEEF, 0, "R5 lo arith");
    // R6 exponent
    drive(1, 3'd4, 0, 0, 0,    16'h0000, 0, "R6 exp zero");
    drive(1, 3'd4, 0, 0, 0,    16'hFFFF, 0, "R6 exp ones");
    drive(1, 3'd4, 0, 0, 0,    16'h4000, 0, "R6 exp 4000");
    drive(1, 3'd4, 0, 0, 0,    16'hBFFF, 0, "R6 exp bfff");
    drive(1, 3'd4, 0, 0, 0,    16'h0003, 0, "R6 exp 0003");
    // R7 normalize
    drive(1, 3'd2, 0, 0, 77,   16'h0003, 0, "R7 norm pos");
    drive(1, 3'd2, 1, 0, -5,   16'hFFF0, 0, "R7 norm neg hi");
    drive(1, 3'd2, 0, 0, 0,    16'h0000, 0, "R7 norm zero");
    // R8 denormalize
    drive(1, 3'd3, 1, 0, 6,    16'h8421, 0, "R8 denorm pos amt");
    drive(1, 3'd3, 1, 0, -6,   16'h8421, 0, "R8 denorm neg amt");
    drive(1, 3'd3, 0, 0, 45,   16'h4000, 0, "R8 denorm far");
    // R9 OR assembly of a 32-bit value
    drive(1, 3'd0, 1, 0, 0,    16'h1234, 0, "R9 hi piece");
    drive(1, 3'd0, 0, 1, 0,    16'h5678, 0, "R9 or lo piece");
    drive(1, 3'd1, 0, 1, 20,   16'h8001, 0, "R9 or arith");
    // R10 block exponent
    drive(0, 3'd0, 0, 0, 0,    16'h0000, 1, "R10 clear idle");
    drive(1, 3'd4, 0, 0, 0,    16'h0100, 0, "R10 min 6");
    drive(1, 3'd4, 0, 0, 0,    16'h0010, 0, "R10 no raise");
    drive(1, 3'd4, 0, 0, 0,    16'hF000, 0, "R10 min 3");
    drive(1, 3'd4, 0, 0, 0,    16'h0400, 1, "R10 clear with exp");
    drive(1, 3'd0, 0, 0, 2,    16'h0001, 1, "R10 clear during shift");
    // R11 ignored inputs
    drive(0, 3'd0, 1, 1, 9,    16'hFFFF, 0, "R11 idle");
    drive(1, 3'd5, 0, 0, 3,    16'h1111, 0, "R11 opcode 5");
    drive(1, 3'd7, 1, 1, -3,   16'h0001, 0, "R11 opcode 7");
    drive(0, 3'd4, 0, 0, 0,    16'h0000, 0, "R11 idle exp");
    // mixed sweep
    for (int n = 0; n < 400; n++) begin
      logic [2:0] oc = 3'($urandom_range(0, 5));
      drive(1'($urandom_range(0, 7) != 0), oc, 1'($urandom), 1'($urandom_range(0, 3) == 0),
            $urandom_range(0, 100) - 50, 16'($urandom), 1'($urandom_range(0, 15) == 0),
            "R2 R3 R6 R7 R8 R9 R10 sweep");
    end
    drive(0, 3'd0, 0, 0, 0, 16'h0, 0, "R11 tail");
    repeat (3) @(posedge clk);
    #1;
    finish_run();
  end
endmodule